// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the completion events of a set of DMA channels and turns them into one interrupt line. Every channel raises three kinds of single-cycle event: half of its buffer has moved, one descriptor has finished, or the whole descriptor chain has ended. Each event latches a sticky pending bit. A matching enable bit decides whether that pending bit can drive the shared interrupt.

Pending and enable bits are packed four bits per channel and eight channels per 32-bit word. The default of sixteen channels therefore needs two enable words and two pending words. Software reads and writes these words over a plain register bus, made of a write strobe, a byte address, write data and combinational read data. It acknowledges events by writing ones to the pending words. A status word shows the live busy flag of every channel.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, every enable word and pending word reads zero and `irq` is low.
- R2: An event pulse on channel c sets pending bit (c mod 8)*4+k in pending word c/8, with k = 0 for half-transfer, 1 for descriptor done and 2 for chain end. This happens on the next clock edge and does not depend on the enable bit.
- R3: A write to byte address 0x00 stores the enable bits for channels 0..7, and a write to 0x04 stores them for channels 8..15. Both read back from the same addresses.
- R4: Bit 3 of every 4-bit channel field, in both enable and pending words, always reads zero and ignores writes.
- R5: A write to 0x10 (channels 0..7) or 0x14 (channels 8..15) clears each pending bit whose written bit is one. Pending bits written as zero keep their value.
- R6: When an event pulse and a clearing write hit the same pending bit on the same edge, the bit remains set.
- R7: `irq` is high exactly when at least one pending bit is set together with its enable bit.
- R8: Address 0x30 reads the `ch_busy` inputs in bits 15:0 and zero above them. A write to 0x30 changes no register.
- R9: Any other address reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_half | input | 16 | Half-transfer event pulses, one per channel |
| evt_pkg | input | 16 | Descriptor-done event pulses, one per channel |
| evt_queue | input | 16 | Chain-end event pulses, one per channel |
| ch_busy | input | 16 | Live busy flag per channel |
| irq | output | 1 | Aggregated interrupt |

## Verification
The bench builds the block with its defaults: sixteen channels, eight channels per word and a 32-bit data path. These give two banks, so it covers the step from channel 7 to channel 8, where the event crosses into the second word, and it covers writes aimed at the wrong bank. Directed steps cover an event arriving while a clear of the same bit is written, writes to the status and unmapped addresses, and reserved-bit masking. A long random stretch then drives events, busy flags and writes together and compares against the model on every cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int DW       = 32;  // register width
  localparam int FW       = 4;   // bits per channel field
  localparam int CPW      = DW / FW;  // channels per word
  localparam int EVT_N    = 3;   // live event bits per field
  localparam int EV_HALF  = 0;
  localparam int EV_PKG   = 1;
  localparam int EV_QUEUE = 2;

  // Mask of the implemented bits in a packed word (reserved bits cleared).
  function automatic logic [DW-1:0] live_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int c = 0; c < CPW; c++)
      for (int k = 0; k < EVT_N; k++)
        m[c*FW + k] = 1'b1;
    return m;
  endfunction

  // Bit position of event k of a channel inside its word.
  function automatic int field_bit(input int ch, input int k);
    return (ch % CPW) * FW + k;
  endfunction
endpackage

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  input  logic [CPW-1:0] evt_half,
  input  logic [CPW-1:0] evt_pkg,
  input  logic [CPW-1:0] evt_queue,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] pend_q,
  output logic          bank_irq
);
  localparam logic [DW-1:0] MASK = live_mask();

  logic [DW-1:0] evt_word;
  logic [DW-1:0] clr_word;
  logic [DW-1:0] pend_nxt;

  for (genvar c = 0; c < CPW; c++) begin : g_field
    logic [FW-1:0] fld;
    always_comb begin
      fld = '0;
      fld[EV_HALF]  = evt_half[c];
      fld[EV_PKG]   = evt_pkg[c];
      fld[EV_QUEUE] = evt_queue[c];
    end
    assign evt_word[c*FW +: FW] = fld;
  end

  assign clr_word = clr_we ? wdata : '0;
  assign pend_nxt = ((pend_q & ~clr_word) | evt_word) & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_we) en_q <= wdata & MASK;
      pend_q <= pend_nxt;
    end
  end

  assign bank_irq = |(en_q & pend_q);

  // R2: a pending bit only rises when its event pulsed.
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_word)) == '0));

  // R6: every pulsed event is pending after the edge, whatever was written.
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_word != '0) |=> ((pend_q & $past(evt_word)) == $past(evt_word)));

  // R5: a clear without a colliding event leaves the bit low.
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend_q & $past(wdata) & ~$past(evt_word)) == '0));

  // R3: enables only move on a write to this bank.
  a_r3_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q));

  // R4: reserved field bits never become set.
  a_r4_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q | pend_q) & ~MASK) == '0);
endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
  import dma_irq_pkg::*;
#(
  parameter int NUM_BANK = 2,
  parameter int NUM_CH   = 16,
  parameter int ADDR_W   = 8,
  parameter int EN_OFF   = 'h00,
  parameter int PEND_OFF = 'h10,
  parameter int STAT_OFF = 'h30
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NUM_BANK*DW-1:0] en_all,
  input  logic [NUM_BANK*DW-1:0] pend_all,
  input  logic [NUM_CH-1:0]      busy,
  output logic [DW-1:0]          rdata
);
  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANK; b++) begin
      if (addr == ADDR_W'(EN_OFF + 4*b))   rdata = en_all[b*DW +: DW];
      if (addr == ADDR_W'(PEND_OFF + 4*b)) rdata = pend_all[b*DW +: DW];
    end
    if (addr == ADDR_W'(STAT_OFF)) rdata = DW'(busy);
  end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NUM_CH-1:0] evt_half,
  input  logic [NUM_CH-1:0] evt_pkg,
  input  logic [NUM_CH-1:0] evt_queue,
  input  logic [NUM_CH-1:0] ch_busy,
  output logic              irq
);
  localparam int NUM_BANK = (NUM_CH + CPW - 1) / CPW;
  localparam int PAD_CH   = NUM_BANK * CPW;
  localparam int EN_OFF   = 'h00;
  localparam int PEND_OFF = 'h10;
  localparam int STAT_OFF = 'h30;

  logic [PAD_CH-1:0]      h_pad, p_pad, q_pad;
  logic [NUM_BANK*DW-1:0] en_all, pend_all;
  logic [NUM_BANK-1:0]    bank_irq;
  logic [NUM_BANK-1:0]    en_we, clr_we;

  assign h_pad = PAD_CH'(evt_half);
  assign p_pad = PAD_CH'(evt_pkg);
  assign q_pad = PAD_CH'(evt_queue);

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    assign en_we[b]  = bus_wr && (bus_addr == ADDR_W'(EN_OFF + 4*b));
    assign clr_we[b] = bus_wr && (bus_addr == ADDR_W'(PEND_OFF + 4*b));

    dma_irq_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_we    (en_we[b]),
      .clr_we   (clr_we[b]),
      .wdata    (bus_wdata),
      .evt_half (h_pad[b*CPW +: CPW]),
      .evt_pkg  (p_pad[b*CPW +: CPW]),
      .evt_queue(q_pad[b*CPW +: CPW]),
      .en_q     (en_all[b*DW +: DW]),
      .pend_q   (pend_all[b*DW +: DW]),
      .bank_irq (bank_irq[b])
    );
  end

  dma_irq_rdmux #(
    .NUM_BANK(NUM_BANK), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
    .EN_OFF(EN_OFF), .PEND_OFF(PEND_OFF), .STAT_OFF(STAT_OFF)
  ) u_rdmux (
    .addr    (bus_addr),
    .en_all  (en_all),
    .pend_all(pend_all),
    .busy    (ch_busy),
    .rdata   (bus_rdata)
  );

  assign irq = |bank_irq;

  // R8/R9: a write that hits no bank leaves every enable word unchanged.
  a_r9_stray_write_no_en: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && en_we == '0) |=> $stable(en_all));

  // R7: with nothing pending the interrupt is low.
  a_r7_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all == '0) |-> !irq);
endmodule

// File: tb/dma_irq_agg_bench.sv
module dma_irq_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] evt_half = '0, evt_pkg = '0, evt_queue = '0, ch_busy = '0;
  logic        irq;

  always #2.5 clk = ~clk;

  dma_irq_agg u_dma_irq_agg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_half(evt_half),
    .evt_pkg(evt_pkg), .evt_queue(evt_queue), .ch_busy(ch_busy), .irq(irq)
  );

  int vectors = 0;
  int errors  = 0;
  string tag = "";
  logic [31:0] m_en [2];
  logic [31:0] m_pend [2];
  localparam logic [31:0] LIVE = 32'h7777_7777;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return m_en[0];
      8'h04: return m_en[1];
      8'h10: return m_pend[0];
      8'h14: return m_pend[1];
      8'h30: return {16'h0, ch_busy};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string auto_tag(input logic [7:0] a);
    case (a)
      8'h00, 8'h04: return "R3";
      8'h10, 8'h14: return "R5";
      8'h30: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare();
    logic [31:0] er;
    logic ei;
    string t;
    er = model_read(bus_addr);
    ei = ((m_en[0] & m_pend[0]) != 0) || ((m_en[1] & m_pend[1]) != 0);
    t = (tag != "") ? tag : auto_tag(bus_addr);
    vectors++;
    if (bus_rdata !== er) begin
      errors++;
      $display("FAIL %s rdata @%02h actual %08h expected %08h", t, bus_addr, bus_rdata, er);
    end
    vectors++;
    if (irq !== ei) begin
      errors++;
      $display("FAIL R7 irq actual %0b expected %0b", irq, ei);
    end
  endtask

  task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [15:0] h, input logic [15:0] p,
                      input logic [15:0] q, input logic [15:0] busy);
    logic [31:0] ev [2];
    @(negedge clk);
    compare();
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    evt_half = h; evt_pkg = p; evt_queue = q; ch_busy = busy;
    ev[0] = '0; ev[1] = '0;
    for (int ch = 0; ch < 16; ch++) begin
      ev[ch / 8][(ch % 8) * 4 + 0] = h[ch];
      ev[ch / 8][(ch % 8) * 4 + 1] = p[ch];
      ev[ch / 8][(ch % 8) * 4 + 2] = q[ch];
    end
    if (wr && a == 8'h00) m_en[0] = d & LIVE;
    if (wr && a == 8'h04) m_en[1] = d & LIVE;
    for (int w = 0; w < 2; w++) begin
      logic [31:0] clr;
      clr = (wr && a == (8'h10 + 8'(4 * w))) ? d : 32'h0;
      m_pend[w] = ((m_pend[w] & ~clr) | ev[w]) & LIVE;
    end
  endtask

  task automatic idle_read(input logic [7:0] a, input logic [15:0] busy);
    step(1'b0, a, 32'h0, 16'h0, 16'h0, 16'h0, busy);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    m_en[0] = '0; m_en[1] = '0; m_pend[0] = '0; m_pend[1] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values on every register
    tag = "R1";
    idle_read(8'h00, 16'h0); idle_read(8'h04, 16'h0);
    idle_read(8'h10, 16'h0); idle_read(8'h14, 16'h0);
    idle_read(8'h10, 16'h0);
    // R2: descriptor-done on ch5, enables off -> word0 bit 21, irq low
    tag = "R2";
    step(1'b0, 8'h10, 0, 16'h0, 16'h0020, 16'h0, 16'h0);
    // R2: half on ch7 and chain end on ch8 (bank boundary)
    step(1'b0, 8'h14, 0, 16'h0080, 16'h0, 16'h0100, 16'h0);
    idle_read(8'h10, 16'h0);
    // R4: reserved bits dropped from enable write
    tag = "R4";
    step(1'b1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0, 0);
    idle_read(8'h00, 16'h0);
    // R7: irq now high (checked every cycle); R5: zero write keeps bits
    tag = "R5";
    step(1'b1, 8'h10, 32'h0, 0, 0, 0, 0);
    idle_read(8'h10, 16'h0);
    step(1'b1, 8'h10, 32'hFFFF_FFFF, 0, 0, 0, 0);
    idle_read(8'h10, 16'h0);
    // R6: chain end on ch12 collides with its clear (word1 bit 18)
    tag = "R6";
    step(1'b1, 8'h14, 32'h0004_0000, 0, 0, 16'h1000, 0);
    idle_read(8'h14, 16'h0);
    // R3: second bank enable
    tag = "R3";
    step(1'b1, 8'h04, 32'h0004_0000, 0, 0, 0, 0);
    idle_read(8'h04, 16'h0);
    // R8: status word and a write to it
    tag = "R8";
    idle_read(8'h30, 16'hA5C3);
    step(1'b1, 8'h30, 32'hFFFF_FFFF, 0, 0, 0, 16'hA5C3);
    idle_read(8'h04, 16'h0);
    // R9: unmapped read and write
    tag = "R9";
    idle_read(8'h08, 16'h0);
    step(1'b1, 8'h08, 32'hFFFF_FFFF, 0, 0, 0, 0);
    idle_read(8'h00, 16'h0);
    idle_read(8'h3C, 16'h0);
    tag = "";

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] addrs [7];
      logic [7:0] a;
      addrs = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h30, 8'h08, 8'h20};
      a = addrs[$urandom_range(0, 6)];
      step(($urandom_range(0, 9) < 3), a, $urandom,
           16'($urandom & $urandom & $urandom),
           16'($urandom & $urandom & $urandom),
           16'($urandom & $urandom & $urandom),
           16'($urandom));
    end
    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule